// File: doc/BRIEF.md
# Microprogram Sequencer with Variable-Format Branching

This block is the control unit of a microcoded datapath. It holds an 8-bit microprogram counter and a control store of microinstructions. Every cycle it shows the control field of the current microinstruction on its output, and it chooses the next microaddress in one of four ways: the next address in sequence, an entry point looked up from the opcode in the instruction register, a return to the fetch routine at address 0, or a conditional jump on the ALU zero and negative flags.

Each microinstruction has one of two formats, and its top bit says which. A control word drives the datapath and then sequences itself. A branch word drives no control lines, tests one flag condition and holds a jump target. The control store output is registered, so each microinstruction takes exactly one clock. The store contents come from a function inside the design. The datapath drives the opcode and the flags.

Top module: `useq_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after reset is released, `upc` is 0x00 and `ctrl_out` is 0x0001, which is the first fetch word.
- R2: A control word has bit 18 = 0. Bits [17:2] appear on `ctrl_out` during the cycle in which its address is on `upc`.
- R3: A control word whose sequencing bits [1:0] are 00 or 11 is followed in the next cycle by address `upc`+1, wrapping modulo 256.
- R4: A control word with sequencing bits 01 dispatches. The next address comes from the opcode: 000000 goes to 0x10, 100011 to 0x20, 101011 to 0x30, 000100 to 0x40 and 000010 to 0x50.
- R5: A control word with sequencing bits 10 is followed by address 0x00.
- R6: A branch word has bit 18 = 1. During its cycle, `ctrl_out` is all zero.
- R7: In a branch word, bits [9:8] select the condition: 00 always, 01 zero flag set, 10 zero flag clear, 11 negative flag set. When the condition holds, the next address is the target in bits [7:0].
- R8: When the condition of a branch word does not hold, the next address is `upc`+1.
- R9: The opcode is used only in a dispatch cycle, and the flags are used only in a branch cycle. A change at any other time has no effect on the sequence.
- R10: An opcode that is not in the R4 list dispatches to the handler at 0xF0.
- R11: The microprogram is stored as follows, as (ctrl, seq) pairs for control words and (cond, target) pairs for branch words:
  - 00:(0001,00)
  - 01:(0002,01)
  - 10:(0010,00)
  - 11:(0020,10)
  - 20:(0100,00)
  - 21:branch(neg,24)
  - 22:(0200,10)
  - 24:(0400,10)
  - 30:branch(zero,34)
  - 31:(0800,10)
  - 34:(1000,10)
  - 40:branch(nonzero,44)
  - 41:(2000,10)
  - 44:(4000,10)
  - 50:branch(always,11)
  - F0:(8000,10)
  - Every other address holds (0000,10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Opcode field from the instruction register |
| flag_zero | input | 1 | ALU result-is-zero flag |
| flag_neg | input | 1 | ALU result-is-negative flag |
| upc | output | 8 | Current microaddress |
| ctrl_out | output | 16 | Control signals of the current microinstruction |

## Verification
The assertions require that the opcode and the two flags are known and do not change within the cycle in which a dispatch or branch word reads them. They also require that the stored microprogram contains no unknown bits. The stimulus meets this by changing these inputs only at the falling clock edge. Under these conditions, the assertions check that each chosen next address shows up on `upc` one edge later. This holds for the increment, dispatch, return and taken-branch paths.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int unsigned UA_W   = 8;
  localparam int unsigned CTRL_W = 16;
  localparam int unsigned OP_W   = 6;
  localparam int unsigned SEQ_W  = 2;
  localparam int unsigned UI_W   = 1 + CTRL_W + SEQ_W;
  localparam int unsigned PAD_W  = UI_W - 1 - 2 - UA_W;

  typedef logic [UA_W-1:0]   uaddr_t;
  typedef logic [UI_W-1:0]   uword_t;
  typedef logic [CTRL_W-1:0] ctrl_t;
  typedef logic [OP_W-1:0]   opc_t;

  typedef enum logic [1:0] {SEQ_NEXT = 2'b00, SEQ_DISPATCH = 2'b01,
                            SEQ_FETCH = 2'b10, SEQ_SPARE = 2'b11} seq_e;
  typedef enum logic [1:0] {CC_ALWAYS = 2'b00, CC_ZERO = 2'b01,
                            CC_NONZERO = 2'b10, CC_NEG = 2'b11} cond_e;

  function automatic uword_t ctl_word(input ctrl_t c, input seq_e s);
    return {1'b0, c, s};
  endfunction

  function automatic uword_t br_word(input cond_e c, input uaddr_t t);
    return {1'b1, {PAD_W{1'b0}}, c, t};
  endfunction

  function automatic uaddr_t seq_incr(input uaddr_t a);
    return a + uaddr_t'(1);
  endfunction

  function automatic logic cond_met(input cond_e c, input logic z, input logic n);
    case (c)
      CC_ALWAYS:  return 1'b1;
      CC_ZERO:    return z;
      CC_NONZERO: return !z;
      default:    return n;
    endcase
  endfunction

  function automatic uaddr_t opcode_entry(input opc_t op);
    case (op)
      6'b000000: return 8'h10;
      6'b100011: return 8'h20;
      6'b101011: return 8'h30;
      6'b000100: return 8'h40;
      6'b000010: return 8'h50;
      default:   return 8'hF0;
    endcase
  endfunction

  function automatic uword_t ucode_at(input uaddr_t a);
    case (a)
      8'h00: return ctl_word(16'h0001, SEQ_NEXT);
      8'h01: return ctl_word(16'h0002, SEQ_DISPATCH);
      8'h10: return ctl_word(16'h0010, SEQ_NEXT);
      8'h11: return ctl_word(16'h0020, SEQ_FETCH);
      8'h20: return ctl_word(16'h0100, SEQ_NEXT);
      8'h21: return br_word(CC_NEG, 8'h24);
      8'h22: return ctl_word(16'h0200, SEQ_FETCH);
      8'h24: return ctl_word(16'h0400, SEQ_FETCH);
      8'h30: return br_word(CC_ZERO, 8'h34);
      8'h31: return ctl_word(16'h0800, SEQ_FETCH);
      8'h34: return ctl_word(16'h1000, SEQ_FETCH);
      8'h40: return br_word(CC_NONZERO, 8'h44);
      8'h41: return ctl_word(16'h2000, SEQ_FETCH);
      8'h44: return ctl_word(16'h4000, SEQ_FETCH);
      8'h50: return br_word(CC_ALWAYS, 8'h11);
      8'hF0: return ctl_word(16'h8000, SEQ_FETCH);
      default: return ctl_word(16'h0000, SEQ_FETCH);
    endcase
  endfunction
endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  uaddr_t addr_nxt,
  output uword_t word_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= ucode_at('0);
    else        word_q <= ucode_at(addr_nxt);
  end
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
(
  input  opc_t   opcode,
  output uaddr_t entry
);
  always_comb entry = opcode_entry(opcode);
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
(
  input  uaddr_t upc_i,
  input  uword_t word_i,
  input  uaddr_t entry_i,
  input  logic   zero_i,
  input  logic   neg_i,
  output uaddr_t nxt_o,
  output ctrl_t  ctrl_o,
  output logic   is_branch_o,
  output logic   taken_o,
  output uaddr_t target_o,
  output logic   disp_o,
  output logic   ret_o
);
  seq_e  sq;
  cond_e cc;

  always_comb begin
    is_branch_o = word_i[UI_W-1];
    sq          = seq_e'(word_i[SEQ_W-1:0]);
    cc          = cond_e'(word_i[UA_W+1:UA_W]);
    target_o    = word_i[UA_W-1:0];
    taken_o     = is_branch_o && cond_met(cc, zero_i, neg_i);
    disp_o      = !is_branch_o && (sq == SEQ_DISPATCH);
    ret_o       = !is_branch_o && (sq == SEQ_FETCH);
    ctrl_o      = is_branch_o ? '0 : word_i[CTRL_W+SEQ_W-1:SEQ_W];
    if (taken_o)     nxt_o = target_o;
    else if (disp_o) nxt_o = entry_i;
    else if (ret_o)  nxt_o = '0;
    else             nxt_o = seq_incr(upc_i);
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic              flag_zero,
  input  logic              flag_neg,
  output logic [UA_W-1:0]   upc,
  output logic [CTRL_W-1:0] ctrl_out
);
  uaddr_t car_q, nxt, entry, br_target;
  uword_t mir;
  logic   is_branch, br_taken, disp, ret;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) car_q <= '0;
    else        car_q <= nxt;
  end

  useq_store u_store (.clk(clk), .rst_n(rst_n), .addr_nxt(nxt), .word_q(mir));

  useq_dispatch u_disp (.opcode(opcode_i), .entry(entry));

  useq_next_addr u_next (
    .upc_i(car_q), .word_i(mir), .entry_i(entry),
    .zero_i(flag_zero), .neg_i(flag_neg),
    .nxt_o(nxt), .ctrl_o(ctrl_out), .is_branch_o(is_branch),
    .taken_o(br_taken), .target_o(br_target), .disp_o(disp), .ret_o(ret)
  );

  assign upc = car_q;
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk
  import useq_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input uaddr_t upc,
  input ctrl_t  ctrl_out,
  input logic   is_branch,
  input logic   br_taken,
  input uaddr_t br_target,
  input logic   disp,
  input uaddr_t disp_addr,
  input logic   ret
);
  AST_RESET_FETCH: assert property (@(posedge clk) !rst_n |=> upc == '0); // R1

  AST_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_taken && !disp && !ret) |=> upc == uaddr_t'($past(upc) + 8'd1)); // R3

  AST_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    disp |=> upc == $past(disp_addr)); // R4

  AST_RETURN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ret |=> upc == '0); // R5

  AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> upc == $past(br_target)); // R7

  AST_FORMAT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    is_branch |-> !disp && !ret); // R6
endmodule

bind useq_ctrl useq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .upc(upc), .ctrl_out(ctrl_out),
  .is_branch(is_branch), .br_taken(br_taken), .br_target(br_target),
  .disp(disp), .disp_addr(entry), .ret(ret)
);

// File: tb/sim_useq_ctrl.sv
module sim_useq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  opcode_i = 6'd0;
  logic        flag_zero = 1'b0;
  logic        flag_neg = 1'b0;
  logic [7:0]  upc;
  logic [15:0] ctrl_out;
  int n_chk = 0;
  int n_fail = 0;

  useq_ctrl u0 (.clk(clk), .rst_n(rst_n), .opcode_i(opcode_i),
                .flag_zero(flag_zero), .flag_neg(flag_neg),
                .upc(upc), .ctrl_out(ctrl_out));

  always #4 clk = ~clk;

  task automatic chk_now(input logic [7:0] ea, input logic [15:0] ec, input string tag);
    n_chk++;
    if (upc !== ea || ctrl_out !== ec) begin
      n_fail++;
      $display("FAIL %s: upc=%h ctrl=%h expected upc=%h ctrl=%h", tag, upc, ctrl_out, ea, ec);
    end
  endtask

  task automatic chk(input logic [7:0] ea, input logic [15:0] ec, input string tag);
    chk_now(ea, ec, tag);
    @(negedge clk);
  endtask

  task automatic fetch_to(input logic [5:0] op, input logic z, input logic n);
    opcode_i = op; flag_zero = z; flag_neg = n;
    chk(8'h00, 16'h0001, "R2 fetch word R3 increment");
    chk(8'h01, 16'h0002, "R4 dispatch word");
  endtask

  task automatic scen_rtype();
    fetch_to(6'b000000, 1'b0, 1'b0);
    chk(8'h10, 16'h0010, "R4 entry 0x10");
    chk(8'h11, 16'h0020, "R3 step to 0x11");
  endtask

  task automatic scen_load(input logic n);
    fetch_to(6'b100011, 1'b0, n);
    opcode_i = 6'b000000;
    chk(8'h20, 16'h0100, "R4 entry 0x20");
    chk(8'h21, 16'h0000, "R6 branch word quiet");
    if (n) chk(8'h24, 16'h0400, "R7 negative taken");
    else   chk(8'h22, 16'h0200, "R8 negative not taken");
    chk_now(8'h00, 16'h0001, "R5 return to fetch");
  endtask

  task automatic scen_store(input logic z);
    fetch_to(6'b101011, z, 1'b1);
    chk(8'h30, 16'h0000, "R6 branch word quiet");
    if (z) chk(8'h34, 16'h1000, "R7 zero taken");
    else   chk(8'h31, 16'h0800, "R8 zero not taken");
  endtask

  task automatic scen_beq(input logic z);
    fetch_to(6'b000100, z, 1'b0);
    chk(8'h40, 16'h0000, "R6 branch word quiet");
    if (z) chk(8'h41, 16'h2000, "R8 nonzero not taken");
    else   chk(8'h44, 16'h4000, "R7 nonzero taken");
  endtask

  task automatic scen_jump();
    fetch_to(6'b000010, 1'b1, 1'b0);
    flag_zero = 1'b0; flag_neg = 1'b1; opcode_i = 6'b111111;
    chk(8'h50, 16'h0000, "R7 always branch");
    chk(8'h11, 16'h0020, "R7 always target, R9 inputs ignored");
    chk_now(8'h00, 16'h0001, "R5 return after always");
  endtask

  task automatic scen_unknown();
    fetch_to(6'b111111, 1'b0, 1'b0);
    chk(8'hF0, 16'h8000, "R10 unmapped opcode handler");
    chk_now(8'h00, 16'h0001, "R5 return from handler");
  endtask

  task automatic scen_reset_mid();
    fetch_to(6'b000000, 1'b0, 1'b0);
    chk_now(8'h10, 16'h0010, "R11 routine before reset");
    rst_n = 1'b0;
    #1;
    chk_now(8'h00, 16'h0001, "R1 reset mid-routine");
    @(negedge clk);
    rst_n = 1'b1;
    chk(8'h00, 16'h0001, "R1 first cycle after reset");
    chk_now(8'h01, 16'h0002, "R3 increment after reset");
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk_now(8'h00, 16'h0001, "R1 during reset");
    rst_n = 1'b1;
    scen_rtype();
    scen_load(1'b1);
    scen_load(1'b0);
    scen_store(1'b1);
    scen_store(1'b0);
    scen_beq(1'b0);
    scen_beq(1'b1);
    scen_jump();
    scen_unknown();
    scen_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule